// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Code Register

This block is the digital front end of a two-channel 12-bit digital-to-analog converter that sits on an 8-bit parallel bus. A host builds each 12-bit code from two byte writes. One write carries the 8-bit low part. The other write carries the 4-bit high part, right-justified on the bus. The two writes may come in either order. A byte-select input picks which half a write strobe updates, and a channel-select input picks the channel.

Each channel is double-buffered. An input register collects the two halves. A separate output register holds the code that the converter sees. In automatic mode, the output register takes the input register's value on the clock edge where the second half of a pair lands. In strobed mode, the output register changes only on a load strobe. That strobe updates both channels at once. A per-channel flag shows that a complete word is waiting in the input register and has not yet been transferred.

Top module: `dual_dac_loader`

## Requirements
- R1: While reset is asserted, every input register and every output code is 0 and every word_ready flag is 0.
- R2: A write with hi_sel=0 places bus_data[7:0] into bits [7:0] of the selected channel's input register.
- R3: A write with hi_sel=1 places bus_data[3:0] into bits [11:8] of the selected channel's input register. bus_data[7:4] is ignored.
- R4: A pair is complete once both halves have been written since the last transfer, in either order (low then high, or high then low).
- R5: With auto_xfer=1, the write that completes a pair copies the updated input register to that channel's code_out, visible after that clock edge, and clears the channel's half tracking. The first half of a pair leaves code_out unchanged.
- R6: With auto_xfer=0, a completed pair leaves code_out unchanged and holds word_ready=1 until a load strobe.
- R7: Writing the same half twice overwrites it and does not complete the pair. There is no transfer, and word_ready stays 0.
- R8: load_stb=1 copies every channel's input register to its code_out on the same edge, whether or not the pair is complete, and clears all half tracking and word_ready flags.
- R9: When load_stb coincides with a write, the written channel's code_out receives the input value that includes that write.
- R10: A write changes only the channel given by ch_sel. Other channels' input registers, codes and flags stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Parallel data bus |
| wr_stb | input | 1 | Write strobe, one write per cycle it is high |
| hi_sel | input | 1 | 0 = low 8-bit half, 1 = high 4-bit half |
| ch_sel | input | 1 | Channel addressed by a write |
| auto_xfer | input | 1 | 1 = transfer on pair completion, 0 = transfer only on load_stb |
| load_stb | input | 1 | Copies all input registers to the output codes |
| code_out | output | 24 | Output codes, channel n at bits [12n+11:12n] |
| word_ready | output | 2 | Per channel: a complete word is waiting untransferred |

## Verification
The bench writes the high half first as well as last. A design that counted writes instead of tracking halves would fail in two ways. It would transfer after a repeated low write, or it would miss a high-then-low pair. The bench puts a value with nonzero upper nibble on the bus during a high write, which exposes a design that lets bits [7:4] leak into the code. It issues a load strobe in the same cycle as a write and after only one half has been written. A design that copied the stale register value, or that waited for a complete pair before loading, would show the wrong code on the following cycle.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;

   // Width of a select field able to address n items (at least one bit)
   function automatic int unsigned sel_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned CH_W   = 1
) (
   input  logic              wr_stb,
   input  logic [CH_W-1:0]   ch_sel,
   output logic [NUM_CH-1:0] wr_en
);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      assign wr_en[i] = wr_stb && (ch_sel == CH_W'(i));
   end

endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              hi_sel,
   input  logic [BUS_W-1:0]  bus_data,
   input  logic              auto_xfer,
   input  logic              load_stb,
   output logic [CODE_W-1:0] code_q,
   output logic              ready
);

   localparam int unsigned HI_W = CODE_W - BUS_W;

   logic [CODE_W-1:0] in_q, in_d, dac_d;
   logic              lo_q, hi_q, lo_d, hi_d;
   logic              pair_done, xfer;

   always_comb begin
      in_d = in_q;
      lo_d = lo_q;
      hi_d = hi_q;
      if (wr_en) begin
         if (hi_sel) begin
            in_d[CODE_W-1:BUS_W] = bus_data[HI_W-1:0];
            hi_d                 = 1'b1;
         end else begin
            in_d[BUS_W-1:0] = bus_data;
            lo_d            = 1'b1;
         end
      end
   end

   // Completion happens only on the write that sets the last missing half
   assign pair_done = wr_en && lo_d && hi_d && !(lo_q && hi_q);
   assign xfer      = load_stb || (auto_xfer && pair_done);
   assign dac_d     = xfer ? in_d : code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q   <= '0;
         code_q <= '0;
         lo_q   <= 1'b0;
         hi_q   <= 1'b0;
      end else begin
         in_q   <= in_d;
         code_q <= dac_d;
         lo_q   <= xfer ? 1'b0 : lo_d;
         hi_q   <= xfer ? 1'b0 : hi_d;
      end
   end

   assign ready = lo_q && hi_q;

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
   import dac_loader_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned CODE_W = 12,
   parameter int unsigned NUM_CH = 2,
   localparam int unsigned CH_W  = sel_width(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [BUS_W-1:0]         bus_data,
   input  logic                     wr_stb,
   input  logic                     hi_sel,
   input  logic [CH_W-1:0]          ch_sel,
   input  logic                     auto_xfer,
   input  logic                     load_stb,
   output logic [NUM_CH*CODE_W-1:0] code_out,
   output logic [NUM_CH-1:0]        word_ready
);

   if (CODE_W <= BUS_W || CODE_W > 2*BUS_W) begin : g_bad_width
      $error("CODE_W must exceed BUS_W and fit in two bus writes");
   end
   if (NUM_CH < 1) begin : g_bad_count
      $error("NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0] wr_en;

   dac_wr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
      .wr_stb (wr_stb),
      .ch_sel (ch_sel),
      .wr_en  (wr_en)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dac_chan_slice #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en[i]),
         .hi_sel    (hi_sel),
         .bus_data  (bus_data),
         .auto_xfer (auto_xfer),
         .load_stb  (load_stb),
         .code_q    (code_out[i*CODE_W +: CODE_W]),
         .ready     (word_ready[i])
      );
   end

endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk #(
   parameter int unsigned CODE_W = 12,
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned CH_W   = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_stb,
   input logic [CH_W-1:0]          ch_sel,
   input logic                     auto_xfer,
   input logic                     load_stb,
   input logic [NUM_CH*CODE_W-1:0] code_out,
   input logic [NUM_CH-1:0]        word_ready
);

   // R8
   load_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (word_ready == '0));

   // R6
   strobed_holds_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !auto_xfer && !load_stb) |=> $stable(code_out));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R10
      untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!load_stb && !(wr_stb && ch_sel == CH_W'(i)))
         |=> $stable(code_out[i*CODE_W +: CODE_W]));

      // R4
      ready_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(word_ready[i]) |-> $past(wr_stb && ch_sel == CH_W'(i) && !load_stb));
   end

endmodule

bind dual_dac_loader dual_dac_loader_chk #(
   .CODE_W(CODE_W), .NUM_CH(NUM_CH), .CH_W(CH_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .ch_sel     (ch_sel),
   .auto_xfer  (auto_xfer),
   .load_stb   (load_stb),
   .code_out   (code_out),
   .word_ready (word_ready)
);

// File: tb/dual_dac_loader_bench.sv
`timescale 1ns/1ps
module dual_dac_loader_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_data = '0;
   logic        wr_stb = 1'b0;
   logic        hi_sel = 1'b0;
   logic [0:0]  ch_sel = '0;
   logic        auto_xfer = 1'b1;
   logic        load_stb = 1'b0;
   logic [23:0] code_out;
   logic [1:0]  word_ready;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dual_dac_loader u_dual_dac_loader (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .wr_stb(wr_stb),
      .hi_sel(hi_sel), .ch_sel(ch_sel), .auto_xfer(auto_xfer),
      .load_stb(load_stb), .code_out(code_out), .word_ready(word_ready)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   function automatic int code(input int ch);
      return int'(code_out[ch*12 +: 12]);
   endfunction

   // One write cycle; outputs are checked at the following falling edge
   task automatic wr(input int ch, input bit hi, input logic [7:0] d, input bit ld);
      ch_sel   = ch[0:0];
      hi_sel   = hi;
      bus_data = d;
      wr_stb   = 1'b1;
      load_stb = ld;
      @(negedge clk);
      wr_stb   = 1'b0;
      load_stb = 1'b0;
      bus_data = '0;
   endtask

   task automatic load_only();
      load_stb = 1'b1;
      @(negedge clk);
      load_stb = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 code0", code(0), 0);
      chk("R1 code1", code(1), 0);
      chk("R1 ready", int'(word_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_auto_low_first();
      auto_xfer = 1'b1;
      wr(0, 0, 8'hA5, 0);
      chk("R5 first half no copy", code(0), 0);
      wr(0, 1, 8'h3C, 0);
      chk("R3 R4 R5 low then high", code(0), 'hCA5);
      chk("R5 tracking cleared", int'(word_ready[0]), 0);
      chk("R10 ch1 untouched", code(1), 0);
   endtask

   task automatic t_auto_high_first();
      wr(1, 1, 8'h07, 0);
      chk("R4 high half alone", code(1), 0);
      wr(1, 0, 8'h12, 0);
      chk("R4 high then low", code(1), 'h712);
      chk("R10 ch0 untouched", code(0), 'hCA5);
   endtask

   task automatic t_repeat_half();
      wr(0, 0, 8'h11, 0);
      wr(0, 0, 8'h22, 0);
      chk("R7 no transfer", code(0), 'hCA5);
      chk("R7 not ready", int'(word_ready[0]), 0);
      wr(0, 1, 8'h05, 0);
      chk("R7 overwrite kept", code(0), 'h522);
   endtask

   task automatic t_strobed();
      auto_xfer = 1'b0;
      wr(0, 0, 8'h33, 0);
      wr(0, 1, 8'h09, 0);
      chk("R6 code held", code(0), 'h522);
      chk("R6 ready set", int'(word_ready[0]), 1);
      @(negedge clk);
      @(negedge clk);
      chk("R6 still held", code(0), 'h522);
      wr(1, 0, 8'h44, 0);
      wr(1, 1, 8'h01, 0);
      chk("R6 both ready", int'(word_ready), 3);
      load_only();
      chk("R8 ch0 loaded", code(0), 'h933);
      chk("R8 ch1 loaded", code(1), 'h144);
      chk("R8 ready cleared", int'(word_ready), 0);
   endtask

   task automatic t_partial_load();
      wr(0, 0, 8'hEE, 0);
      chk("R2 low only held", code(0), 'h933);
      load_only();
      chk("R2 R8 partial load", code(0), 'h9EE);
      chk("R8 ch1 same", code(1), 'h144);
   endtask

   task automatic t_load_with_write();
      wr(1, 1, 8'hFF, 1);
      chk("R9 R3 write with load", code(1), 'hF44);
      chk("R9 ready clear", int'(word_ready), 0);
      chk("R9 ch0 reloaded", code(0), 'h9EE);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_auto_low_first();
      t_auto_high_first();
      t_repeat_half();
      t_strobed();
      t_partial_load();
      t_load_with_write();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule